// File: doc/BRIEF.md
# Multiplexer Logic Cell with Optional Output Register

This block is a fine-grain programmable logic cell made of three 2:1 multiplexers. Two first-level multiplexers each pick one input from a data pair: the A pair under select `sa`, the B pair under select `sb`. A second-level multiplexer then picks one of these two results. Its select is the OR of two output-select inputs, `s0` and `s1`. The output is therefore a Shannon expansion on whichever variable drives the final select.

A Boolean function is mapped onto the cell by splitting it into cofactors. The variables go to the select pins and the cofactors go to the data pins. Any pin the function does not use is tied to a constant 0 or 1.

A configuration input picks what appears at the output:
- the combinational result, or
- the same result captured by a positive-edge D flip-flop, which has a synchronous active-high reset.

The cell is replicated across `LANES` independent bit lanes that share the clock, the reset and the configuration input.

Top module: `mlc_cell`

## Requirements
- R1: In each lane the A-path multiplexer passes `a0` when `sa` is 0 and `a1` when `sa` is 1.
- R2: In each lane the B-path multiplexer passes `b0` when `sb` is 0 and `b1` when `sb` is 1.
- R3: In each lane the cell result follows the B path when `s0` or `s1` is 1, and follows the A path when both are 0.
- R4: With `cfg_reg` = 0, `y` equals the combinational cell result in the same cycle, with no clock edge involved.
- R5: With `cfg_reg` = 1, `y` shows the cell result sampled at the most recent rising clock edge and holds that value until the next rising edge.
- R6: While `rst` = 1 at a rising edge, the output register is cleared to 0, so `y` reads 0 in registered mode after that edge.
- R7: For all 16 combinations of A, B, C and D, the connection `a0`=D, `a1`=1, `b0`=D, `b1`=1, `sa`=C, `sb`=A, `s0`=0, `s1`=B produces F = A·B + B'·C + D.
- R8: Tying unused pins to constants yields further functions. With `sa`=X, `s0`=`s1`=0 and `a1`=Y: `a0`=0 gives X·Y, and `a0`=Y with `a1`=1 gives X+Y. With `s1`=X, `s0`=0, `a0`=P, `a1`=P, `sa`=0, `b0`=Q, `b1`=Q, `sb`=0, the cell gives X ? Q : P.
- R9: Lanes are independent: each bit of `y` depends only on the same bit of the eight logic inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| cfg_reg | input | 1 | 0: combinational output, 1: registered output |
| a0 | input | LANES | A-pair data, chosen when `sa` is 0 |
| a1 | input | LANES | A-pair data, chosen when `sa` is 1 |
| b0 | input | LANES | B-pair data, chosen when `sb` is 0 |
| b1 | input | LANES | B-pair data, chosen when `sb` is 1 |
| sa | input | LANES | A-pair select |
| sb | input | LANES | B-pair select |
| s0 | input | LANES | Output select, ORed with `s1` |
| s1 | input | LANES | Output select, ORed with `s0` |
| y | output | LANES | Cell output |

## Verification
In combinational mode every result is due in the same cycle as the stimulus. The bench drives inputs on the falling clock edge and samples `y` one nanosecond later, so no clock edge lies between stimulus and sample.

In registered mode the result is due one rising edge after the inputs settle. The bench drives on a falling edge, lets one rising edge pass, and samples at the following falling edge. It then changes the inputs again before the next rising edge and confirms that `y` holds.

The reset value is checked one rising edge after `rst` is raised, with registered mode selected.

// File: rtl/mlc_pkg.sv
package mlc_pkg;

  typedef enum logic {
    OUT_COMB = 1'b0,
    OUT_REG  = 1'b1
  } out_mode_e;

  // 2:1 selection, one bit
  function automatic logic pick2(input logic lo, input logic hi, input logic sel);
    return sel ? hi : lo;
  endfunction

  // final-stage select: either output-select input steers to the B path
  function automatic logic final_sel(input logic os0, input logic os1);
    return os0 | os1;
  endfunction

endpackage

// File: rtl/mlc_mux2.sv
module mlc_mux2 (
  input  logic d_lo,
  input  logic d_hi,
  input  logic sel,
  output logic q
);
  import mlc_pkg::*;

  always_comb q = pick2(d_lo, d_hi, sel);

endmodule

// File: rtl/mlc_out_sel.sv
module mlc_out_sel (
  input  logic os0,
  input  logic os1,
  output logic take_b
);
  import mlc_pkg::*;

  always_comb take_b = final_sel(os0, os1);

endmodule

// File: rtl/mlc_seq.sv
module mlc_seq #(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] d,
  output logic [LANES-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end

  // R6: a reset edge leaves the register cleared
  a_r6_reset_clears: assert property (@(posedge clk) rst |=> (q == '0))
    else $error("register not cleared after reset");

  // R5: the register holds what was presented at the previous edge
  a_r5_captures_prev: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (q == $past(d)))
    else $error("register did not capture its input");

endmodule

// File: rtl/mlc_cell.sv
module mlc_cell #(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_reg,
  input  logic [LANES-1:0] a0,
  input  logic [LANES-1:0] a1,
  input  logic [LANES-1:0] b0,
  input  logic [LANES-1:0] b1,
  input  logic [LANES-1:0] sa,
  input  logic [LANES-1:0] sb,
  input  logic [LANES-1:0] s0,
  input  logic [LANES-1:0] s1,
  output logic [LANES-1:0] y
);
  import mlc_pkg::*;

  // internal events brought out as named wires
  logic [LANES-1:0] path_a;
  logic [LANES-1:0] path_b;
  logic [LANES-1:0] take_b;
  logic [LANES-1:0] comb_out;
  logic [LANES-1:0] reg_out;
  out_mode_e        mode;

  always_comb mode = out_mode_e'(cfg_reg);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    mlc_mux2 u_mux_a (
      .d_lo (a0[i]),
      .d_hi (a1[i]),
      .sel  (sa[i]),
      .q    (path_a[i])
    );

    mlc_mux2 u_mux_b (
      .d_lo (b0[i]),
      .d_hi (b1[i]),
      .sel  (sb[i]),
      .q    (path_b[i])
    );

    mlc_out_sel u_osel (
      .os0    (s0[i]),
      .os1    (s1[i]),
      .take_b (take_b[i])
    );

    mlc_mux2 u_mux_f (
      .d_lo (path_a[i]),
      .d_hi (path_b[i]),
      .sel  (take_b[i]),
      .q    (comb_out[i])
    );
  end

  mlc_seq #(.LANES(LANES)) u_seq (
    .clk (clk),
    .rst (rst),
    .d   (comb_out),
    .q   (reg_out)
  );

  always_comb y = (mode == OUT_REG) ? reg_out : comb_out;

  // R1: lanes with sa low pass a0 on the A path, lanes with sa high pass a1
  a_r1_path_a: assert property (@(posedge clk) disable iff (rst)
    (((~sa & (path_a ^ a0)) | (sa & (path_a ^ a1))) == '0))
    else $error("A path mismatch");

  // R2: the same for the B path under sb
  a_r2_path_b: assert property (@(posedge clk) disable iff (rst)
    (((~sb & (path_b ^ b0)) | (sb & (path_b ^ b1))) == '0))
    else $error("B path mismatch");

  // R3: both output selects low -> A path, otherwise B path
  a_r3_final_select: assert property (@(posedge clk) disable iff (rst)
    ((((~s0 & ~s1) & (comb_out ^ path_a)) | ((s0 | s1) & (comb_out ^ path_b))) == '0))
    else $error("final select mismatch");

  // R4: combinational mode shows the cell result directly
  a_r4_comb_mode: assert property (@(posedge clk) disable iff (rst)
    !cfg_reg |-> (y == comb_out))
    else $error("combinational output mismatch");

  // R5: registered mode shows the value from the previous edge
  a_r5_reg_mode: assert property (@(posedge clk) disable iff (rst)
    cfg_reg |=> (!cfg_reg || (y == $past(comb_out))))
    else $error("registered output mismatch");

endmodule

// File: tb/mlc_cell_tb.sv
module mlc_cell_tb;

  localparam int LANES = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cfg_reg = 1'b0;
  logic [LANES-1:0] a0 = '0, a1 = '0, b0 = '0, b1 = '0;
  logic [LANES-1:0] sa = '0, sb = '0, s0 = '0, s1 = '0;
  logic [LANES-1:0] y;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  mlc_cell #(.LANES(LANES)) u_dut (
    .clk(clk), .rst(rst), .cfg_reg(cfg_reg),
    .a0(a0), .a1(a1), .b0(b0), .b1(b1),
    .sa(sa), .sb(sb), .s0(s0), .s1(s1),
    .y(y)
  );

  // reference: code bits 0..7 = a0,a1,b0,b1,sa,sb,s0,s1
  function automatic logic ref_cell(input logic [7:0] c);
    logic ra, rb;
    ra = (c[0] & ~c[4]) | (c[1] & c[4]);
    rb = (c[2] & ~c[5]) | (c[3] & c[5]);
    return (c[6] || c[7]) ? rb : ra;
  endfunction

  function automatic logic [LANES-1:0] ref_vec(input logic [LANES*8-1:0] codes);
    logic [LANES-1:0] r;
    for (int l = 0; l < LANES; l++) r[l] = ref_cell(codes[l*8 +: 8]);
    return r;
  endfunction

  task automatic apply_codes(input logic [LANES*8-1:0] codes);
    for (int l = 0; l < LANES; l++) begin
      a0[l] = codes[l*8+0]; a1[l] = codes[l*8+1];
      b0[l] = codes[l*8+2]; b1[l] = codes[l*8+3];
      sa[l] = codes[l*8+4]; sb[l] = codes[l*8+5];
      s0[l] = codes[l*8+6]; s1[l] = codes[l*8+7];
    end
  endtask

  task automatic check(input string req, input logic [LANES-1:0] got,
                       input logic [LANES-1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: y=%b expected %b", req, got, exp);
    end
  endtask

  // R6: reset clears register, seen in registered mode
  task automatic t_reset;
    @(negedge clk);
    cfg_reg = 1'b1; rst = 1'b1;
    apply_codes({LANES{8'h02}});   // every lane would drive 1 if captured
    sa = '1;
    @(negedge clk); #1;
    check("R6 reset", y, '0);
    @(negedge clk);
    rst = 1'b0; cfg_reg = 1'b0;
  endtask

  // R1 R2 R3 R4 R9: all 256 codes, different code in every lane
  task automatic t_exhaustive_comb;
    logic [LANES*8-1:0] codes;
    cfg_reg = 1'b0;
    for (int k = 0; k < 256; k += LANES) begin
      @(negedge clk);
      for (int l = 0; l < LANES; l++) codes[l*8 +: 8] = 8'((k + l * 37) % 256);
      apply_codes(codes);
      #1;
      check("R1/R2/R3/R4/R9 exhaustive", y, ref_vec(codes));
    end
  endtask

  // R7: F = A.B + B'.C + D
  task automatic t_shannon_example;
    for (int v = 0; v < 16; v += LANES) begin
      logic [LANES-1:0] exp;
      @(negedge clk);
      for (int l = 0; l < LANES; l++) begin
        logic va, vb, vc, vd;
        {va, vb, vc, vd} = 4'(v + l);
        a0[l] = vd; a1[l] = 1'b1; b0[l] = vd; b1[l] = 1'b1;
        sa[l] = vc; sb[l] = va; s0[l] = 1'b0; s1[l] = vb;
        exp[l] = (va & vb) | (~vb & vc) | vd;
      end
      #1;
      check("R7 example mapping", y, exp);
    end
  endtask

  // R8: AND, OR and 2:1 selection by constant ties
  task automatic t_const_ties;
    for (int v = 0; v < 4; v++) begin
      logic vx, vy;
      {vx, vy} = 2'(v);
      @(negedge clk);
      s0 = '0; s1 = '0; sa = {LANES{vx}}; a0 = '0; a1 = {LANES{vy}};
      b0 = '1; b1 = '1; sb = '0;
      #1;
      check("R8 AND", y, {LANES{vx & vy}});
      a0 = {LANES{vy}}; a1 = '1;
      #1;
      check("R8 OR", y, {LANES{vx | vy}});
    end
    for (int v = 0; v < 8; v++) begin
      logic vx, vp, vq;
      {vx, vp, vq} = 3'(v);
      @(negedge clk);
      s0 = '0; s1 = {LANES{vx}}; sa = '0; sb = '0;
      a0 = {LANES{vp}}; a1 = {LANES{vp}}; b0 = {LANES{vq}}; b1 = {LANES{vq}};
      #1;
      check("R8 select", y, {LANES{vx ? vq : vp}});
    end
  endtask

  // R5: registered mode captures at edge and holds between edges
  task automatic t_registered;
    logic [LANES*8-1:0] codes;
    logic [LANES-1:0]   exp;
    @(negedge clk);
    cfg_reg = 1'b1;
    for (int k = 0; k < 12; k++) begin
      for (int l = 0; l < LANES; l++) codes[l*8 +: 8] = 8'(k * 53 + l * 91 + 7);
      apply_codes(codes);
      exp = ref_vec(codes);
      @(negedge clk); #1;
      check("R5 capture", y, exp);
      apply_codes(~codes);   // change inputs before the next edge
      #1;
      check("R5 hold", y, exp);
      @(negedge clk);
    end
    cfg_reg = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog: run did not finish");
    if (!done) begin
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_exhaustive_comb();
    t_shannon_example();
    t_const_ties();
    t_registered();
    t_reset();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule